// File: doc/BRIEF.md
# Transaction Status and Verification Unit

This unit keeps the per-processor state of a hardware memory transaction. It also executes the three instructions that end or check a transaction: the consistency check, the commit and the abort. A processor pipeline presents one instruction per cycle on a valid strobe with an opcode. For the check and the commit, the unit returns a one-bit result one cycle later. The same opcode field also carries a notice for each transactional load or store. The first such notice opens a transaction.

Two flags describe the state. `tx_active` says a transaction is in progress. `tx_clean` says no conflict has been seen so far. A transaction that has seen a conflict stays active with `tx_clean` low. This is an orphan: it keeps executing, but it is certain to fail when it is checked or committed. A conflict is any of the following, arriving while a clean transaction is in progress: a BUSY reply to a transactional bus cycle, any interrupt line, or an overflow of the transactional cache. The unit then pulses `cache_abort` so that the transactional cache drops its tentative lines.

On commit, the unit pulses `cache_commit` and nothing else. Write-back to memory happens later, when the cache evicts or invalidates a line.

Top module: `txn_status_unit`

## Requirements
- R1: After synchronous reset, `tx_active`=0, `tx_clean`=1, and `result_valid`, `cache_commit` and `cache_abort` are all 0.
- R2: `instr_op` encoding: 0=check, 1=commit, 2=abort, 3=transactional access notice. An access notice while `tx_active`=0 sets `tx_active`=1 with `tx_clean`=1. An access notice while `tx_active`=1 changes no flag.
- R3: A check on a clean state returns `result_value`=1 with `result_valid`=1, drives no cache strobe and leaves both flags unchanged.
- R4: A check on an orphan returns 0, pulses `cache_abort`, and ends the transaction (`tx_active`=0, `tx_clean`=1).
- R5: A commit with `tx_clean`=1 pulses `cache_commit`, returns 1 and leaves `tx_active`=0, `tx_clean`=1. This also applies when no transaction is open.
- R6: A commit on an orphan pulses `cache_abort` (not `cache_commit`), returns 0 and ends the transaction.
- R7: An abort instruction always pulses `cache_abort`, gives no result (`result_valid`=0) and leaves `tx_active`=0, `tx_clean`=1.
- R8: A BUSY reply while a clean transaction is active clears `tx_clean`, pulses `cache_abort` and keeps `tx_active`=1.
- R9: Any asserted interrupt line, or a cache overflow, has the same effect as R8.
- R10: BUSY, interrupt and overflow have no effect while no transaction is active or while the transaction is already an orphan: no strobe, flags unchanged.
- R11: When an event of R8/R9 and an instruction arrive in the same cycle, the event applies first. A commit in that cycle returns 0 and produces a single `cache_abort` pulse with no `cache_commit`.
- R12: All outputs are registered and reflect the inputs sampled at the previous rising edge. `cache_commit` and `cache_abort` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction strobe |
| instr_op | input | 2 | Opcode (see R2) |
| busy_reply | input | 1 | BUSY reply to a transactional bus cycle |
| irq | input | IRQ_LINES | Interrupt lines |
| cache_overflow | input | 1 | Transactional cache overflow |
| result_valid | output | 1 | Result of a check or commit is present |
| result_value | output | 1 | Boolean result |
| cache_commit | output | 1 | Commit strobe to the transactional cache |
| cache_abort | output | 1 | Abort strobe to the transactional cache |
| tx_active | output | 1 | Transaction in progress |
| tx_clean | output | 1 | No conflict seen |

## Verification
A wrong flag state becomes visible on `tx_active`/`tx_clean` one cycle after the edge that caused it. It shows up again at the next check or commit, which returns the wrong boolean and drives the wrong cache strobe. A lost conflict shows as a missing `cache_abort` in the cycle after the event, and as a commit that succeeds when it must fail. The bench keeps its own copy of the two flags, derived from the requirements, and compares all six outputs every cycle. Any divergence is therefore reported within one cycle.

// File: rtl/txu_pkg.sv
package txu_pkg;
  parameter int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    TXOP_CHECK  = 2'd0,
    TXOP_COMMIT = 2'd1,
    TXOP_ABORT  = 2'd2,
    TXOP_ACCESS = 2'd3
  } txop_e;

  typedef struct packed {
    logic active;
    logic clean;
  } txflags_t;

  typedef struct packed {
    logic rvalid;
    logic rvalue;
    logic commit;
    logic abort;
  } txresp_t;

  localparam txflags_t FLAGS_IDLE = '{active: 1'b0, clean: 1'b1};
  localparam txresp_t  RESP_NONE  = '{rvalid: 1'b0, rvalue: 1'b0, commit: 1'b0, abort: 1'b0};
endpackage

// File: rtl/txu_trigger.sv
module txu_trigger
  import txu_pkg::*;
#(
  parameter int IRQ_LINES = 4
) (
  input  txflags_t             flags,
  input  logic                 busy_reply,
  input  logic [IRQ_LINES-1:0] irq,
  input  logic                 cache_overflow,
  output logic                 fault_hit
);
  logic any_irq;

  generate
    if (IRQ_LINES == 1) begin : g_single
      assign any_irq = irq[0];
    end else begin : g_multi
      assign any_irq = |irq;
    end
  endgenerate

  // Only a clean, open transaction can be hit; an orphan is already doomed.
  assign fault_hit = flags.active & flags.clean &
                     (busy_reply | any_irq | cache_overflow);
endmodule

// File: rtl/txu_decide.sv
module txu_decide
  import txu_pkg::*;
(
  input  txflags_t                flags,
  input  logic                    instr_valid,
  input  logic [txu_pkg::OP_W-1:0] instr_op,
  input  logic                    fault_hit,
  output txflags_t                flags_nxt,
  output txresp_t                 resp_nxt
);
  logic  eff_clean;
  txop_e op;

  assign eff_clean = flags.clean & ~fault_hit;
  assign op        = txop_e'(instr_op);

  always_comb begin
    flags_nxt        = '{active: flags.active, clean: eff_clean};
    resp_nxt         = RESP_NONE;
    resp_nxt.abort   = fault_hit;
    if (instr_valid) begin
      unique case (op)
        TXOP_CHECK: begin
          resp_nxt.rvalid = 1'b1;
          resp_nxt.rvalue = eff_clean;
          if (!eff_clean) begin
            resp_nxt.abort = 1'b1;
            flags_nxt      = FLAGS_IDLE;
          end
        end
        TXOP_COMMIT: begin
          resp_nxt.rvalid = 1'b1;
          resp_nxt.rvalue = eff_clean;
          resp_nxt.commit = eff_clean;
          resp_nxt.abort  = ~eff_clean;
          flags_nxt       = FLAGS_IDLE;
        end
        TXOP_ABORT: begin
          resp_nxt.abort = 1'b1;
          flags_nxt      = FLAGS_IDLE;
        end
        TXOP_ACCESS: begin
          flags_nxt.active = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txu_regs.sv
module txu_regs
  import txu_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  txflags_t flags_nxt,
  input  txresp_t  resp_nxt,
  output txflags_t flags_q,
  output txresp_t  resp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= FLAGS_IDLE;
      resp_q  <= RESP_NONE;
    end else begin
      flags_q <= flags_nxt;
      resp_q  <= resp_nxt;
    end
  end
endmodule

// File: rtl/txn_status_unit.sv
module txn_status_unit
  import txu_pkg::*;
#(
  parameter int IRQ_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 instr_valid,
  input  logic [1:0]           instr_op,
  input  logic                 busy_reply,
  input  logic [IRQ_LINES-1:0] irq,
  input  logic                 cache_overflow,
  output logic                 result_valid,
  output logic                 result_value,
  output logic                 cache_commit,
  output logic                 cache_abort,
  output logic                 tx_active,
  output logic                 tx_clean
);
  txflags_t flags_q, flags_nxt;
  txresp_t  resp_q, resp_nxt;
  logic     fault_hit;

  txu_trigger #(.IRQ_LINES(IRQ_LINES)) u_trig (
    .flags          (flags_q),
    .busy_reply     (busy_reply),
    .irq            (irq),
    .cache_overflow (cache_overflow),
    .fault_hit      (fault_hit)
  );

  txu_decide u_dec (
    .flags       (flags_q),
    .instr_valid (instr_valid),
    .instr_op    (instr_op),
    .fault_hit   (fault_hit),
    .flags_nxt   (flags_nxt),
    .resp_nxt    (resp_nxt)
  );

  txu_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .flags_nxt (flags_nxt),
    .resp_nxt  (resp_nxt),
    .flags_q   (flags_q),
    .resp_q    (resp_q)
  );

  assign result_valid = resp_q.rvalid;
  assign result_value = resp_q.rvalue;
  assign cache_commit = resp_q.commit;
  assign cache_abort  = resp_q.abort;
  assign tx_active    = flags_q.active;
  assign tx_clean     = flags_q.clean;
endmodule

// File: rtl/txu_chk.sv
module txu_chk #(
  parameter int IRQ_LINES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 instr_valid,
  input logic [1:0]           instr_op,
  input logic                 busy_reply,
  input logic [IRQ_LINES-1:0] irq,
  input logic                 cache_overflow,
  input logic                 result_valid,
  input logic                 result_value,
  input logic                 cache_commit,
  input logic                 cache_abort,
  input logic                 tx_active,
  input logic                 tx_clean
);
  logic any_evt;
  assign any_evt = busy_reply | (|irq) | cache_overflow;

  assert_idle_clean_R2: assert property (@(posedge clk) disable iff (rst)
    !tx_active |-> tx_clean);

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(cache_commit && cache_abort));

  assert_commit_result_R5: assert property (@(posedge clk) disable iff (rst)
    cache_commit |-> (result_valid && result_value));

  assert_abort_op_R7: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_op == 2'd2) |=> (cache_abort && !tx_active && !result_valid));

  assert_orphan_commit_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_active && !tx_clean && instr_valid && instr_op == 2'd1)
      |=> (result_valid && !result_value && cache_abort && !cache_commit));

  assert_event_hit_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_active && tx_clean && any_evt) |=> (cache_abort && !cache_commit));

  assert_orphan_ignores_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_active && !tx_clean && !instr_valid) |=> (!cache_abort && tx_active && !tx_clean));

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!tx_active && instr_valid && instr_op == 2'd3) |=> (tx_active && tx_clean));

  assert_no_result_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> !result_valid);
endmodule

bind txn_status_unit txu_chk #(.IRQ_LINES(IRQ_LINES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .instr_valid    (instr_valid),
  .instr_op       (instr_op),
  .busy_reply     (busy_reply),
  .irq            (irq),
  .cache_overflow (cache_overflow),
  .result_valid   (result_valid),
  .result_value   (result_value),
  .cache_commit   (cache_commit),
  .cache_abort    (cache_abort),
  .tx_active      (tx_active),
  .tx_clean       (tx_clean)
);

// File: tb/txn_status_unit_tb.sv
module txn_status_unit_tb;
  localparam int IRQ_LINES = 4;

  typedef struct {
    logic  rv, res, cc, ca, act, cln;
    string tag;
  } exp_t;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 instr_valid = 1'b0;
  logic [1:0]           instr_op = 2'd0;
  logic                 busy_reply = 1'b0;
  logic [IRQ_LINES-1:0] irq = '0;
  logic                 cache_overflow = 1'b0;
  logic result_valid, result_value, cache_commit, cache_abort, tx_active, tx_clean;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];
  logic m_act = 1'b0;
  logic m_cln = 1'b1;

  always #5 clk = ~clk;

  txn_status_unit #(.IRQ_LINES(IRQ_LINES)) u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_op(instr_op),
    .busy_reply(busy_reply), .irq(irq), .cache_overflow(cache_overflow),
    .result_valid(result_valid), .result_value(result_value),
    .cache_commit(cache_commit), .cache_abort(cache_abort),
    .tx_active(tx_active), .tx_clean(tx_clean)
  );

  task automatic compare(exp_t e);
    n_checks++;
    if ({result_valid, result_value, cache_commit, cache_abort, tx_active, tx_clean} !==
        {e.rv, e.res, e.cc, e.ca, e.act, e.cln}) begin
      n_errors++;
      $display("FAIL %s: got rv=%b res=%b cc=%b ca=%b act=%b cln=%b expected rv=%b res=%b cc=%b ca=%b act=%b cln=%b",
               e.tag, result_valid, result_value, cache_commit, cache_abort, tx_active, tx_clean,
               e.rv, e.res, e.cc, e.ca, e.act, e.cln);
    end
  endtask

  // Monitor: outputs settle after the rising edge; compare 2 ns later.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) compare(exp_q.pop_front());
  end

  // Driver: apply one cycle of stimulus and push the requirement-derived outcome.
  task automatic step(input logic v, input logic [1:0] op, input logic bsy,
                      input logic [IRQ_LINES-1:0] iv, input logic ovf, input string tag);
    exp_t e;
    logic fault, eff;
    @(negedge clk);
    instr_valid = v; instr_op = op; busy_reply = bsy; irq = iv; cache_overflow = ovf;
    fault = m_act && m_cln && (bsy || (|iv) || ovf);
    eff   = m_cln && !fault;
    e = '{rv: 1'b0, res: 1'b0, cc: 1'b0, ca: fault, act: 1'b0, cln: 1'b1, tag: tag};
    if (v) begin
      case (op)
        2'd0: begin
          e.rv = 1'b1; e.res = eff;
          if (!eff) begin e.ca = 1'b1; m_act = 1'b0; m_cln = 1'b1; end
        end
        2'd1: begin
          e.rv = 1'b1; e.res = eff; e.cc = eff;
          if (!eff) e.ca = 1'b1;
          m_act = 1'b0; m_cln = 1'b1;
        end
        2'd2: begin e.ca = 1'b1; m_act = 1'b0; m_cln = 1'b1; end
        default: begin m_act = 1'b1; m_cln = eff; end
      endcase
    end else begin
      m_cln = eff;
    end
    e.act = m_act; e.cln = m_cln;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 2'd0, 1'b0, '0, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;  // R1 reset state
    if ({result_valid, cache_commit, cache_abort, tx_active, tx_clean} !== 5'b00001) begin
      n_errors++;
      $display("FAIL R1: got rv=%b cc=%b ca=%b act=%b cln=%b expected 0 0 0 0 1",
               result_valid, cache_commit, cache_abort, tx_active, tx_clean);
    end
    rst = 1'b0;
    idle("R1");
    step(1'b0, 2'd0, 1'b1, 4'b0001, 1'b1, "R10");   // events with no transaction
    step(1'b1, 2'd3, 1'b0, '0, 1'b0, "R2");         // open
    step(1'b1, 2'd3, 1'b0, '0, 1'b0, "R2");         // access while open
    step(1'b1, 2'd0, 1'b0, '0, 1'b0, "R3");         // clean check
    step(1'b0, 2'd0, 1'b1, '0, 1'b0, "R8");         // BUSY -> orphan
    step(1'b0, 2'd0, 1'b1, 4'b1000, 1'b1, "R10");   // orphan ignores events
    step(1'b1, 2'd3, 1'b0, '0, 1'b0, "R2");         // access on orphan
    step(1'b1, 2'd0, 1'b0, '0, 1'b0, "R4");         // check on orphan
    step(1'b1, 2'd3, 1'b0, '0, 1'b0, "R2");
    step(1'b1, 2'd1, 1'b0, '0, 1'b0, "R5");         // clean commit
    step(1'b1, 2'd3, 1'b0, '0, 1'b0, "R2");
    step(1'b0, 2'd0, 1'b0, 4'b0010, 1'b0, "R9");    // interrupt
    step(1'b1, 2'd1, 1'b0, '0, 1'b0, "R6");         // orphan commit
    step(1'b1, 2'd3, 1'b0, '0, 1'b0, "R2");
    step(1'b0, 2'd0, 1'b0, '0, 1'b1, "R9");         // overflow
    step(1'b1, 2'd2, 1'b0, '0, 1'b0, "R7");         // abort orphan
    step(1'b1, 2'd2, 1'b0, '0, 1'b0, "R7");         // abort with nothing open
    step(1'b1, 2'd3, 1'b0, '0, 1'b0, "R2");
    step(1'b1, 2'd1, 1'b1, '0, 1'b0, "R11");        // commit with BUSY same cycle
    step(1'b1, 2'd3, 1'b0, '0, 1'b0, "R2");
    step(1'b1, 2'd0, 1'b0, 4'b0100, 1'b0, "R11");   // check with interrupt same cycle
    step(1'b1, 2'd1, 1'b0, '0, 1'b0, "R5");         // commit with nothing open
    idle("R12");
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(lf[0] | lf[1], lf[3:2], lf[4] & lf[5] & lf[6],
             (lf[7] & lf[8] & lf[9]) ? lf[11:8] : 4'b0000,
             lf[12] & lf[13] & lf[14], "R12");
      end
    end
    idle("R12");
    @(posedge clk); #4;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule